// File: doc/BRIEF.md
# Thread Block Dispatcher with Multi-Resource Admission

This block takes a stream of requests to launch thread blocks and places each one on one of several compute multiprocessors. A request carries a block identifier, the number of threads in the block, the registers it needs and the shared memory it needs. For every multiprocessor the dispatcher keeps four running totals: resident blocks, resident threads, registers in use and shared memory in use. A request is admitted to a multiprocessor only when all four totals still have room for it.

Requests come in through a valid/ready handshake and are served strictly in arrival order. When no multiprocessor can take the request at the head, that request waits and a stall flag is raised. A request that could not fit even on an empty multiprocessor is accepted at once and answered with a reject flag. When a resident block finishes, its multiprocessor index and its four resource amounts are reported on a completion port, and those amounts are returned to that multiprocessor's totals. Running the blocks and issuing their warps are handled elsewhere.

Top module: `blk_dispatch`

## Requirements
- R1: Every accepted request produces exactly one result one cycle after the clock edge that accepted it (`out_valid` high for one cycle, `out_id` equal to the request's id), and a placed block is charged whole to a single multiprocessor.
- R2: A multiprocessor never holds more than MAX_BLK (default 8) resident blocks; a request that would exceed this on every multiprocessor is not placed.
- R3: The threads resident on a multiprocessor never exceed MAX_THR (default 768); a block that fills a multiprocessor to exactly MAX_THR is admitted.
- R4: A block is admitted to a multiprocessor only if its register demand fits in that multiprocessor's remaining registers (MAX_REGS, default 8192) and its shared-memory demand fits in the remaining shared memory (MAX_SMEM, default 16384); exact fills are admitted.
- R5: Among the multiprocessors that can take a block, the one with the lowest index is chosen, and `out_mp` carries its index.
- R6: While the head request fits nowhere, `req_ready` is low, no result is produced, and `stall` is high in the cycle after each clock edge at which a valid request was left unplaced; the same request is placed as soon as room appears.
- R7: A completion (`done_valid` with multiprocessor index and the four amounts) returns all four amounts to that multiprocessor in one clock edge; admission sees the freed room from the cycle after that edge.
- R8: A request with zero threads, more than MAX_BLK_THR (default 512) threads, more registers than MAX_REGS or more shared memory than MAX_SMEM is accepted at once and answered with `out_reject` high and `out_mp` zero, and it consumes no resources.
- R9: After reset every multiprocessor is empty and `out_valid`, `out_reject` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request is taken at this clock edge (placed or rejected) |
| req_id | input | ID_W | Block identifier |
| req_thr | input | TW | Threads in the block |
| req_regs | input | RW | Registers demanded |
| req_smem | input | SW | Shared memory demanded |
| done_valid | input | 1 | A resident block has finished |
| done_mp | input | MP_W | Multiprocessor the finished block was on |
| done_thr | input | TW | Threads to return |
| done_regs | input | RW | Registers to return |
| done_smem | input | SW | Shared memory to return |
| out_valid | output | 1 | Result of an accepted request |
| out_reject | output | 1 | Result is a rejection |
| out_id | output | ID_W | Identifier of the block in the result |
| out_mp | output | MP_W | Multiprocessor chosen (zero on rejection) |
| stall | output | 1 | Head request was left unplaced at the last edge |

## Verification
The assertions take for granted that every completion describes a block that really is resident on the named multiprocessor, with the exact amounts it was charged; under that assumption the per-multiprocessor totals can never underflow and the capacity properties hold. The bench keeps within this by recording every placement it predicts and completing only blocks from that record, with the recorded multiprocessor and amounts. It also never reports a completion on a multiprocessor with no resident block.

// File: rtl/blkd_pkg.sv
package blkd_pkg;

  // outcome held in the result register
  typedef enum logic [1:0] {
    OUT_IDLE    = 2'd0,
    OUT_PLACED  = 2'd1,
    OUT_REFUSED = 2'd2
  } out_kind_e;

  // index width that stays at least one bit wide
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mp_account.sv
// Resource totals of one multiprocessor and the admission test against them.
module mp_account #(
  parameter int MAX_BLK  = 8,
  parameter int MAX_THR  = 768,
  parameter int MAX_REGS = 8192,
  parameter int MAX_SMEM = 16384,
  parameter int TW       = 10,
  parameter int RW       = 14,
  parameter int SW       = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] dem_thr,
  input  logic [RW-1:0] dem_regs,
  input  logic [SW-1:0] dem_smem,
  input  logic          alloc,
  input  logic          free,
  input  logic [TW-1:0] free_thr,
  input  logic [RW-1:0] free_regs,
  input  logic [SW-1:0] free_smem,
  output logic          fit
);

  localparam int BW = $clog2(MAX_BLK + 1);

  logic [BW-1:0] cnt_blk;
  logic [TW-1:0] cnt_thr;
  logic [RW-1:0] cnt_regs;
  logic [SW-1:0] cnt_smem;

  logic [TW:0] thr_sum;
  logic [RW:0] regs_sum;
  logic [SW:0] smem_sum;

  assign thr_sum  = {1'b0, cnt_thr}  + {1'b0, dem_thr};
  assign regs_sum = {1'b0, cnt_regs} + {1'b0, dem_regs};
  assign smem_sum = {1'b0, cnt_smem} + {1'b0, dem_smem};

  assign fit = (cnt_blk < BW'(MAX_BLK))
            && (thr_sum  <= (TW+1)'(MAX_THR))
            && (regs_sum <= (RW+1)'(MAX_REGS))
            && (smem_sum <= (SW+1)'(MAX_SMEM));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_blk  <= '0;
      cnt_thr  <= '0;
      cnt_regs <= '0;
      cnt_smem <= '0;
    end else begin
      cnt_blk  <= cnt_blk  + (alloc ? BW'(1) : '0) - (free ? BW'(1) : '0);
      cnt_thr  <= cnt_thr  + (alloc ? dem_thr  : '0) - (free ? free_thr  : '0);
      cnt_regs <= cnt_regs + (alloc ? dem_regs : '0) - (free ? free_regs : '0);
      cnt_smem <= cnt_smem + (alloc ? dem_smem : '0) - (free ? free_smem : '0);
    end
  end

  p_blk_cap_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_blk <= BW'(MAX_BLK));
  p_thr_cap_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_thr <= TW'(MAX_THR));
  p_regs_cap_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_regs <= RW'(MAX_REGS));
  p_smem_cap_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_smem <= SW'(MAX_SMEM));
  // the selector may only charge a multiprocessor that reported room (R5)
  p_alloc_fits_r5: assert property (@(posedge clk) disable iff (rst)
    alloc |-> fit);
  // input assumption: completions name a multiprocessor with a resident block (R7)
  p_free_resident_r7: assert property (@(posedge clk) disable iff (rst)
    free |-> (cnt_blk != '0));

endmodule

// File: rtl/mp_select.sv
// Lowest-index selection among multiprocessors that have room.
module mp_select #(
  parameter int N    = 4,
  parameter int MP_W = 2
) (
  input  logic [N-1:0]    cand,
  output logic [N-1:0]    grant,
  output logic [MP_W-1:0] grant_idx,
  output logic            any
);

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = MP_W'(i);
        any       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
  import blkd_pkg::*;
#(
  parameter int NUM_MP      = 4,
  parameter int ID_W        = 8,
  parameter int MAX_BLK     = 8,
  parameter int MAX_THR     = 768,
  parameter int MAX_BLK_THR = 512,
  parameter int MAX_REGS    = 8192,
  parameter int MAX_SMEM    = 16384,
  // derived widths; keep at their defaults
  parameter int MP_W        = idx_w(NUM_MP),
  parameter int TW          = $clog2(MAX_THR + 1),
  parameter int RW          = $clog2(MAX_REGS + 2),
  parameter int SW          = $clog2(MAX_SMEM + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [ID_W-1:0] req_id,
  input  logic [TW-1:0]   req_thr,
  input  logic [RW-1:0]   req_regs,
  input  logic [SW-1:0]   req_smem,
  input  logic            done_valid,
  input  logic [MP_W-1:0] done_mp,
  input  logic [TW-1:0]   done_thr,
  input  logic [RW-1:0]   done_regs,
  input  logic [SW-1:0]   done_smem,
  output logic            out_valid,
  output logic            out_reject,
  output logic [ID_W-1:0] out_id,
  output logic [MP_W-1:0] out_mp,
  output logic            stall
);

  logic [NUM_MP-1:0] fit;
  logic [NUM_MP-1:0] grant;
  logic [NUM_MP-1:0] alloc;
  logic [NUM_MP-1:0] free;
  logic [MP_W-1:0]   grant_idx;
  logic              any_fit;
  logic              req_bad;
  logic              place;

  out_kind_e         kind_q;
  logic [ID_W-1:0]   id_q;
  logic [MP_W-1:0]   mp_q;
  logic              stall_q;

  // a demand that no empty multiprocessor could hold
  assign req_bad = (req_thr == '0)
                || (req_thr  > TW'(MAX_BLK_THR))
                || (req_regs > RW'(MAX_REGS))
                || (req_smem > SW'(MAX_SMEM));

  assign place     = req_valid && !req_bad && any_fit;
  assign req_ready = req_bad || any_fit;

  generate
    for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
      assign alloc[g] = place && grant[g];
      assign free[g]  = done_valid && (done_mp == MP_W'(g));

      mp_account #(
        .MAX_BLK  (MAX_BLK),
        .MAX_THR  (MAX_THR),
        .MAX_REGS (MAX_REGS),
        .MAX_SMEM (MAX_SMEM),
        .TW       (TW),
        .RW       (RW),
        .SW       (SW)
      ) acct_i (
        .clk       (clk),
        .rst       (rst),
        .dem_thr   (req_thr),
        .dem_regs  (req_regs),
        .dem_smem  (req_smem),
        .alloc     (alloc[g]),
        .free      (free[g]),
        .free_thr  (done_thr),
        .free_regs (done_regs),
        .free_smem (done_smem),
        .fit       (fit[g])
      );
    end
  endgenerate

  mp_select #(
    .N    (NUM_MP),
    .MP_W (MP_W)
  ) sel_i (
    .cand      (fit),
    .grant     (grant),
    .grant_idx (grant_idx),
    .any       (any_fit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= OUT_IDLE;
      id_q    <= '0;
      mp_q    <= '0;
      stall_q <= 1'b0;
    end else begin
      stall_q <= req_valid && !req_ready;
      if (req_valid && req_bad) begin
        kind_q <= OUT_REFUSED;
        id_q   <= req_id;
        mp_q   <= '0;
      end else if (place) begin
        kind_q <= OUT_PLACED;
        id_q   <= req_id;
        mp_q   <= grant_idx;
      end else begin
        kind_q <= OUT_IDLE;
      end
    end
  end

  assign out_valid  = (kind_q != OUT_IDLE);
  assign out_reject = (kind_q == OUT_REFUSED);
  assign out_id     = id_q;
  assign out_mp     = mp_q;
  assign stall      = stall_q;

  // a block is charged to at most one multiprocessor (R1)
  p_single_mp_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc));
  // an accepted request yields a result at the next edge (R1)
  p_result_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> out_valid);
  // a stalled cycle produces no result (R6)
  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    stall |-> !out_valid);
  // an impossible demand consumes nothing (R8)
  p_reject_no_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bad) |-> (alloc == '0));
  // rejections never name a multiprocessor other than zero (R8)
  p_reject_mp_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_reject) |-> (out_mp == '0));

endmodule

// File: tb/blk_dispatch_tb_top.sv
`timescale 1ns/1ps
module blk_dispatch_tb_top;

  localparam int NMP   = 4;
  localparam int CBLK  = 8;
  localparam int CTHR  = 768;
  localparam int BTHR  = 512;
  localparam int CREGS = 8192;
  localparam int CSMEM = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_id = '0;
  logic [9:0]  req_thr = 10'd1;
  logic [13:0] req_regs = '0;
  logic [14:0] req_smem = '0;
  logic        done_valid = 1'b0;
  logic [1:0]  done_mp = '0;
  logic [9:0]  done_thr = '0;
  logic [13:0] done_regs = '0;
  logic [14:0] done_smem = '0;
  logic        out_valid;
  logic        out_reject;
  logic [7:0]  out_id;
  logic [1:0]  out_mp;
  logic        stall;

  always #2 clk = ~clk;

  blk_dispatch dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_thr(req_thr), .req_regs(req_regs), .req_smem(req_smem),
    .done_valid(done_valid), .done_mp(done_mp), .done_thr(done_thr),
    .done_regs(done_regs), .done_smem(done_smem),
    .out_valid(out_valid), .out_reject(out_reject), .out_id(out_id),
    .out_mp(out_mp), .stall(stall)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // bench-side model of the totals and of the resident blocks
  int mb[NMP], mt[NMP], mr[NMP], ms[NMP];
  bit live[256];
  int lmp[256], lthr[256], lreg[256], lsm[256];
  int nid = 0;

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit never_fits(input int thr, rg, sm);
    return (thr == 0) || (thr > BTHR) || (rg > CREGS) || (sm > CSMEM);
  endfunction

  function automatic int model_pick(input int thr, rg, sm);
    for (int m = 0; m < NMP; m++)
      if (mb[m] < CBLK && mt[m] + thr <= CTHR && mr[m] + rg <= CREGS &&
          ms[m] + sm <= CSMEM)
        return m;
    return -1;
  endfunction

  function automatic void model_add(input int id, m, thr, rg, sm);
    mb[m]++; mt[m] += thr; mr[m] += rg; ms[m] += sm;
    live[id] = 1; lmp[id] = m; lthr[id] = thr; lreg[id] = rg; lsm[id] = sm;
  endfunction

  // res: 0 placed, 1 rejected, 2 stalled
  task automatic issue(input int thr, rg, sm, input string tag, output int res);
    int id, em;
    bit bad;
    id = nid % 256;
    bad = never_fits(thr, rg, sm);
    em = model_pick(thr, rg, sm);
    @(negedge clk);
    req_valid = 1'b1; req_id = 8'(id); req_thr = 10'(thr);
    req_regs = 14'(rg); req_smem = 15'(sm);
    #1;
    chk(int'(req_ready), (bad || em >= 0) ? 1 : 0, {tag, " req_ready"});
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      res = 1; nid++;
      chk(int'(out_valid), 1, {tag, " R8 out_valid"});
      chk(int'(out_reject), 1, {tag, " R8 out_reject"});
      chk(int'(out_mp), 0, {tag, " R8 out_mp"});
      chk(int'(out_id), id, {tag, " R1 out_id"});
    end else if (em >= 0) begin
      res = 0; nid++;
      model_add(id, em, thr, rg, sm);
      chk(int'(out_valid), 1, {tag, " R1 out_valid"});
      chk(int'(out_reject), 0, {tag, " R1 out_reject"});
      chk(int'(out_mp), em, {tag, " R5 out_mp"});
      chk(int'(out_id), id, {tag, " R1 out_id"});
      chk(int'(stall), 0, {tag, " R6 stall low"});
    end else begin
      res = 2;
      chk(int'(out_valid), 0, {tag, " R6 no result"});
      chk(int'(stall), 1, {tag, " R6 stall"});
    end
  endtask

  task automatic retire(input int id);
    @(negedge clk);
    done_valid = 1'b1; done_mp = 2'(lmp[id]); done_thr = 10'(lthr[id]);
    done_regs = 14'(lreg[id]); done_smem = 15'(lsm[id]);
    @(negedge clk);
    done_valid = 1'b0;
    mb[lmp[id]]--; mt[lmp[id]] -= lthr[id];
    mr[lmp[id]] -= lreg[id]; ms[lmp[id]] -= lsm[id];
    live[id] = 0;
  endtask

  task automatic retire_all();
    for (int i = 0; i < 256; i++) if (live[i]) retire(i);
  endtask

  task automatic retire_oldest();
    for (int i = 0; i < 256; i++)
      if (live[i]) begin retire(i); return; end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int r, hid, first_mp2;
    for (int m = 0; m < NMP; m++) begin mb[m] = 0; mt[m] = 0; mr[m] = 0; ms[m] = 0; end
    for (int i = 0; i < 256; i++) live[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: empty and quiet after reset
    chk(int'(out_valid), 0, "R9 out_valid");
    chk(int'(out_reject), 0, "R9 out_reject");
    chk(int'(stall), 0, "R9 stall");
    chk(int'(req_ready), 1, "R9 empty accepts");

    // R2 and R5: small blocks fill block slots in index order
    for (int k = 0; k < NMP * CBLK; k++) issue(16, 16, 16, "R2 fill", r);
    issue(16, 16, 16, "R2 slots full", r);
    chk(r, 2, "R2 stalled when slots exhausted");
    // R7: free one slot on multiprocessor 2; next block lands there
    first_mp2 = -1;
    for (int i = 0; i < 256; i++) if (live[i] && lmp[i] == 2 && first_mp2 < 0) first_mp2 = i;
    retire(first_mp2);
    issue(16, 16, 16, "R7 reuse freed slot", r);
    chk(r, 0, "R7 placed after completion");
    retire_all();

    // R3: thread limit with exact fill
    issue(512, 0, 0, "R3 big0", r);
    issue(512, 0, 0, "R3 big1", r);
    issue(256, 0, 0, "R3 exact 768", r);
    issue(1, 0, 0, "R3 one more", r);
    retire_all();

    // R4: registers and shared memory, exact and one over
    issue(1, 8000, 0, "R4 regs a", r);
    issue(1, 192, 0, "R4 regs exact", r);
    issue(1, 1, 0, "R4 regs over", r);
    issue(1, 0, 16000, "R4 smem a", r);
    issue(1, 0, 384, "R4 smem exact", r);
    issue(1, 0, 1, "R4 smem over", r);
    retire_all();

    // R8: impossible demands
    issue(0, 0, 0, "R8 zero threads", r);
    issue(513, 0, 0, "R8 too many threads", r);
    issue(1023, 0, 0, "R8 max field threads", r);
    issue(1, 8193, 0, "R8 regs over", r);
    issue(1, 0, 16385, "R8 smem over", r);
    chk(int'(req_ready), 1, "R8 nothing consumed");

    // R6: head request held until a completion makes room
    for (int k = 0; k < NMP; k++) issue(385, 0, 0, "R6 prefill", r);
    hid = nid % 256;
    @(negedge clk);
    req_valid = 1'b1; req_id = 8'(hid); req_thr = 10'd512; req_regs = '0; req_smem = '0;
    #1 chk(int'(req_ready), 0, "R6 held not ready");
    @(negedge clk);
    chk(int'(stall), 1, "R6 stall cycle 1");
    chk(int'(out_valid), 0, "R6 no result 1");
    @(negedge clk);
    chk(int'(stall), 1, "R6 stall cycle 2");
    first_mp2 = -1;
    for (int i = 0; i < 256; i++) if (live[i] && lmp[i] == 2) first_mp2 = i;
    done_valid = 1'b1; done_mp = 2'd2; done_thr = 10'(lthr[first_mp2]);
    done_regs = '0; done_smem = '0;
    @(negedge clk);
    done_valid = 1'b0;
    mb[2]--; mt[2] -= lthr[first_mp2]; live[first_mp2] = 0;
    chk(int'(stall), 1, "R7 freed room not seen at same edge");
    chk(int'(out_valid), 0, "R7 no result at free edge");
    #1 chk(int'(req_ready), 1, "R7 room visible next cycle");
    @(negedge clk);
    req_valid = 1'b0;
    chk(int'(out_valid), 1, "R6 held request placed");
    chk(int'(out_mp), 2, "R6 R5 placed on freed mp");
    chk(int'(out_id), hid, "R6 same head id");
    chk(int'(stall), 0, "R6 stall cleared");
    model_add(hid, 2, 512, 0, 0);
    nid++;
    retire_all();

    // mixed sweep against the model; stalls are cleared by retiring the oldest
    for (int k = 0; k < 150; k++) begin
      int thr, rg, sm;
      thr = (k % 10 == 9) ? 513 + (k % 100) : 1 + (k * 149) % 512;
      rg  = (k * 613) % 3000;
      sm  = (k * 1451) % 6000;
      issue(thr, rg, sm, "R5 sweep", r);
      while (r == 2) begin
        retire_oldest();
        issue(thr, rg, sm, "R6 sweep retry", r);
      end
    end
    retire_all();
    issue(BTHR, CREGS, CSMEM, "R4 full block on empty", r);
    chk(r, 0, "R4 whole-capacity block placed");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule